// File: doc/BRIEF.md
# Scanner Channel Clock Sequencer

This block generates the clock for a channel scanner on a sensor chip. The scanner moves one channel forward on each falling edge of that clock and holds a sync line low while it sits at its start channel. The block has two ways to drive the scanner. It can place the scanner on a chosen channel, or it can step the scanner at a fixed rate.

A seek command runs in two stages. First the block clocks the scanner until sync reads low, within a fixed pulse budget. It then issues as many further pulses as the channel value asks for. If the budget runs out, the command stops with an error and the stepping stage is skipped. A continuous command loads a 16-bit auto-reload timer. Each timer rollover then fires one complete scan clock pulse, until a seek command or reset stops the timer.

Commands are single-cycle strobes. A strobe is taken only while the block is idle.

Top module: `scan_clock_seq`

## Requirements
- R1: Reset drives scan_clk, busy, done and seek_err low and stops the continuous timer, so no scan clock pulse appears after reset until a new command arrives.
- R2: Every scan clock pulse is high for exactly HALF_CYCLES (default 10) clock cycles, then low for at least HALF_CYCLES cycles. scan_clk is never high while busy is low.
- R3: In a seek, sync_in is sampled once the low phase of each pulse has ended. While it reads high and budget remains, one more pulse is issued. When it reads low, the seek stage ends.
- R4: The seek stage issues at most SEEK_LIMIT (default 255) pulses. Sync is tested before the budget, so a scanner that reaches its start exactly on pulse 255 still counts as found.
- R5: If sync is still high after SEEK_LIMIT pulses, seek_err rises in the same cycle as done, and no stepping pulses are issued.
- R6: After sync reads low, exactly N further pulses are issued, where N is the 8-bit cmd_value given with the seek command. N = 0 issues none.
- R7: busy is high from the cycle after a seek command is taken until its done pulse. done lasts exactly one cycle, and busy is already low in that cycle.
- R8: A continuous command (cmd_cont = 1) with period value P loads a 16-bit up-counter with {8'hFF, 8'hFF - P}. A pulse starts on each rollover from 16'hFFFF, so successive rising edges are P+1 cycles apart when P+1 exceeds the pulse length. A rollover that lands while a pulse is still running is dropped, which gives 21 cycles between rising edges for P = 0.
- R9: A taken seek command stops the continuous timer. No timer pulse follows the end of the seek.
- R10: A command strobe is ignored while busy is high, both during a seek and during a timer pulse. It changes neither the running pulse count nor the timer.
- R11: seek_err keeps its value until the next accepted command of either kind, which clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_cont | input | 1 | Command kind: 1 = continuous timer, 0 = seek |
| cmd_value | input | VAL_W | Target channel for a seek, period value for continuous mode |
| sync_in | input | 1 | Scanner sync; low marks the start channel |
| scan_clk | output | 1 | Clock to the scanner |
| busy | output | 1 | A seek or a scan clock pulse is in progress |
| done | output | 1 | One-cycle pulse at the end of every seek |
| seek_err | output | 1 | Set when the seek budget ran out without finding sync |

## Verification
The properties take for granted that command strobes are one cycle long and that sync_in only changes at a falling edge of scan_clk, as a real scanner would behave. Under that assumption, every sync sample taken after a low phase sees a settled value. The bench drives sync_in from a scanner model that advances its position on each falling edge of scan_clk, or holds sync high to force a timeout. It only raises cmd_valid at a falling clock edge, for one cycle.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

   typedef enum logic [2:0] {
      SEQ_IDLE,
      SEQ_PROBE,
      SEQ_PROBE_WAIT,
      SEQ_ADVANCE,
      SEQ_ADVANCE_WAIT
   } seq_state_t;

endpackage

// File: rtl/scan_reload_timer.sv
module scan_reload_timer #(
   parameter int TMR_W = 16,
   parameter int VAL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             halt,
   input  logic [VAL_W-1:0] period,
   output logic             tick
);

   logic             running;
   logic [TMR_W-1:0] count;
   logic [TMR_W-1:0] reload_q;
   logic [TMR_W-1:0] reload_new;

   // upper bits all ones, lower bits hold all-ones minus the period value
   if (TMR_W > VAL_W) begin : g_pad
      assign reload_new = {{(TMR_W-VAL_W){1'b1}}, ~period};
   end else begin : g_same
      assign reload_new = ~period[TMR_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running  <= 1'b0;
         count    <= '0;
         reload_q <= '0;
      end else if (load) begin
         running  <= 1'b1;
         count    <= reload_new;
         reload_q <= reload_new;
      end else if (halt) begin
         running  <= 1'b0;
      end else if (running) begin
         count    <= (count == '1) ? reload_q : count + TMR_W'(1);
      end
   end

   assign tick = running && (count == '1);

endmodule

// File: rtl/scan_pulse_gen.sv
module scan_pulse_gen #(
   parameter int HALF_CYCLES = 10
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic clk_o,
   output logic active_o,
   output logic done_o
);

   localparam int PW = (HALF_CYCLES > 1) ? $clog2(HALF_CYCLES) : 1;
   localparam logic [PW-1:0] PHASE_LAST = PW'(HALF_CYCLES - 1);

   logic [PW-1:0] phase_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_o     <= 1'b0;
         active_o  <= 1'b0;
         done_o    <= 1'b0;
         phase_cnt <= '0;
      end else begin
         done_o <= 1'b0;
         if (!active_o) begin
            if (start) begin
               active_o  <= 1'b1;
               clk_o     <= 1'b1;
               phase_cnt <= PHASE_LAST;
            end
         end else if (phase_cnt != '0) begin
            phase_cnt <= phase_cnt - PW'(1);
         end else if (clk_o) begin
            clk_o     <= 1'b0;
            phase_cnt <= PHASE_LAST;
         end else begin
            active_o  <= 1'b0;
            done_o    <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/scan_seek_ctrl.sv
module scan_seek_ctrl
   import scan_seq_pkg::*;
#(
   parameter int VAL_W      = 8,
   parameter int SEEK_LIMIT = 255
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go_seek,
   input  logic             go_any,
   input  logic [VAL_W-1:0] target,
   input  logic             sync_in,
   input  logic             pulse_done,
   output logic             pulse_req,
   output logic             busy_o,
   output logic             done_o,
   output logic             err_o
);

   localparam int SW = $clog2(SEEK_LIMIT + 1);
   localparam logic [SW-1:0] BUDGET = SW'(SEEK_LIMIT);

   seq_state_t       state;
   logic [SW-1:0]    probes;
   logic [VAL_W-1:0] remain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= SEQ_IDLE;
         probes <= '0;
         remain <= '0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
      end else begin
         done_o <= 1'b0;
         unique case (state)
            SEQ_IDLE: begin
               if (go_any) err_o <= 1'b0;
               if (go_seek) begin
                  state  <= SEQ_PROBE;
                  probes <= '0;
                  remain <= target;
               end
            end
            SEQ_PROBE: begin
               if (!sync_in) begin
                  state <= SEQ_ADVANCE;
               end else if (probes == BUDGET) begin
                  err_o  <= 1'b1;
                  done_o <= 1'b1;
                  state  <= SEQ_IDLE;
               end else begin
                  probes <= probes + SW'(1);
                  state  <= SEQ_PROBE_WAIT;
               end
            end
            SEQ_PROBE_WAIT: if (pulse_done) state <= SEQ_PROBE;
            SEQ_ADVANCE: begin
               if (remain == '0) begin
                  done_o <= 1'b1;
                  state  <= SEQ_IDLE;
               end else begin
                  remain <= remain - VAL_W'(1);
                  state  <= SEQ_ADVANCE_WAIT;
               end
            end
            SEQ_ADVANCE_WAIT: if (pulse_done) state <= SEQ_ADVANCE;
            default: state <= SEQ_IDLE;
         endcase
      end
   end

   always_comb begin
      pulse_req = 1'b0;
      if (state == SEQ_PROBE)   pulse_req = sync_in && (probes != BUDGET);
      if (state == SEQ_ADVANCE) pulse_req = (remain != '0);
   end

   assign busy_o = (state != SEQ_IDLE);

endmodule

// File: rtl/scan_clock_seq.sv
module scan_clock_seq #(
   parameter int HALF_CYCLES = 10,
   parameter int SEEK_LIMIT  = 255,
   parameter int VAL_W       = 8,
   parameter int TMR_W       = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_valid,
   input  logic             cmd_cont,
   input  logic [VAL_W-1:0] cmd_value,
   input  logic             sync_in,
   output logic             scan_clk,
   output logic             busy,
   output logic             done,
   output logic             seek_err
);

   if (HALF_CYCLES < 1) begin : g_bad_half
      $error("HALF_CYCLES must be at least 1");
   end
   if (SEEK_LIMIT < 1) begin : g_bad_limit
      $error("SEEK_LIMIT must be at least 1");
   end
   if (TMR_W < VAL_W) begin : g_bad_tmr
      $error("TMR_W must not be narrower than VAL_W");
   end

   logic ctrl_busy, ctrl_req, pulse_active, pulse_done, tmr_tick;
   logic cmd_take, go_seek, go_cont, pulse_start;

   assign busy     = ctrl_busy | pulse_active;
   assign cmd_take = cmd_valid & ~busy;
   assign go_seek  = cmd_take & ~cmd_cont;
   assign go_cont  = cmd_take &  cmd_cont;

   // a command taken this cycle wins over a timer tick
   assign pulse_start = ctrl_req | (tmr_tick & ~ctrl_busy & ~cmd_take);

   scan_reload_timer #(.TMR_W(TMR_W), .VAL_W(VAL_W)) u_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (go_cont),
      .halt   (go_seek),
      .period (cmd_value),
      .tick   (tmr_tick)
   );

   scan_pulse_gen #(.HALF_CYCLES(HALF_CYCLES)) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (pulse_start),
      .clk_o    (scan_clk),
      .active_o (pulse_active),
      .done_o   (pulse_done)
   );

   scan_seek_ctrl #(.VAL_W(VAL_W), .SEEK_LIMIT(SEEK_LIMIT)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_seek    (go_seek),
      .go_any     (cmd_take),
      .target     (cmd_value),
      .sync_in    (sync_in),
      .pulse_done (pulse_done),
      .pulse_req  (ctrl_req),
      .busy_o     (ctrl_busy),
      .done_o     (done),
      .err_o      (seek_err)
   );

endmodule

// File: rtl/scan_clock_seq_chk.sv
module scan_clock_seq_chk #(
   parameter int HALF_CYCLES = 10
) (
   input logic clk,
   input logic rst_n,
   input logic cmd_valid,
   input logic scan_clk,
   input logic busy,
   input logic done,
   input logic seek_err
);

   localparam int CW = $clog2(HALF_CYCLES + 1) + 1;
   localparam logic [CW-1:0] HALF = CW'(HALF_CYCLES);

   logic [CW-1:0] hi_cnt, lo_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_cnt <= '0;
         lo_cnt <= HALF;
      end else if (scan_clk) begin
         hi_cnt <= (hi_cnt == '1) ? hi_cnt : hi_cnt + CW'(1);
         lo_cnt <= '0;
      end else begin
         hi_cnt <= '0;
         lo_cnt <= (lo_cnt >= HALF) ? HALF : lo_cnt + CW'(1);
      end
   end

   AST_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(scan_clk) |-> (hi_cnt == HALF)); // R2
   AST_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scan_clk) |-> (lo_cnt >= HALF)); // R2
   AST_CLK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      scan_clk |-> busy); // R2
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R7
   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R7
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seek_err) |-> done); // R5
   AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !cmd_valid) |=> $stable(seek_err)); // R11

endmodule

bind scan_clock_seq scan_clock_seq_chk #(.HALF_CYCLES(HALF_CYCLES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .scan_clk  (scan_clk),
   .busy      (busy),
   .done      (done),
   .seek_err  (seek_err)
);

// File: tb/test_scan_clock_seq.sv
module test_scan_clock_seq;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic       cmd_cont = 1'b0;
   logic [7:0] cmd_value = '0;
   logic       sync_in;
   logic       scan_clk, busy, done, seek_err;

   logic [7:0] scan_pos = '0;
   logic       stuck = 1'b0;
   int         fall_cnt = 0;
   int         rise_cnt = 0;
   int         last_rise = 0;
   int         cyc = 0;
   logic       sc_prev = 1'b0;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         finished = 0;

   always #5 clk = ~clk;

   scan_clock_seq i_scan_clock_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_cont(cmd_cont),
      .cmd_value(cmd_value), .sync_in(sync_in), .scan_clk(scan_clk),
      .busy(busy), .done(done), .seek_err(seek_err)
   );

   // scanner model: position advances on each falling scan clock edge
   assign sync_in = stuck || (scan_pos != 8'd0);
   always @(negedge scan_clk) begin
      scan_pos = scan_pos + 8'd1;
      fall_cnt = fall_cnt + 1;
   end

   always @(posedge clk) cyc = cyc + 1;
   always @(negedge clk) begin
      if (scan_clk && !sc_prev) begin
         rise_cnt  = rise_cnt + 1;
         last_rise = cyc;
      end
      sc_prev = scan_clk;
   end

   typedef struct packed {
      logic [7:0] start;
      logic [7:0] chan;
      logic       stuck;
      logic [9:0] pulses;
      logic       err;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{8'd0,   8'd5,   1'b0, 10'd5,   1'b0},
      '{8'd0,   8'd0,   1'b0, 10'd0,   1'b0},
      '{8'd250, 8'd3,   1'b0, 10'd9,   1'b0},
      '{8'd1,   8'd7,   1'b0, 10'd262, 1'b0},
      '{8'd0,   8'd4,   1'b1, 10'd255, 1'b1},
      '{8'd0,   8'd0,   1'b0, 10'd0,   1'b0},
      '{8'd200, 8'd255, 1'b0, 10'd311, 1'b0}
   };

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // called at a falling clock edge
   task automatic send_cmd(input logic cont, input logic [7:0] val);
      cmd_valid = 1'b1;
      cmd_cont  = cont;
      cmd_value = val;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 2000; k++) begin
         if (!busy) break;
         @(negedge clk);
      end
   endtask

   task automatic wait_done(input string tag);
      bit got = 0;
      for (int k = 0; k < 20000; k++) begin
         @(negedge clk);
         if (done) begin
            got = 1;
            break;
         end
      end
      check(tag, int'(got), 1);
   endtask

   task automatic get_gap(output int gap);
      int r0 = rise_cnt;
      int t1 = 0;
      for (int k = 0; k < 2000 && rise_cnt < r0 + 1; k++) @(negedge clk);
      t1 = last_rise;
      for (int k = 0; k < 2000 && rise_cnt < r0 + 2; k++) @(negedge clk);
      gap = last_rise - t1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      summary();
   end

   initial begin
      int gap;
      int f0;
      repeat (3) @(negedge clk);
      check("R1 reset scan_clk", int'(scan_clk), 0);
      check("R1 reset busy", int'(busy), 0);
      check("R1 reset done", int'(done), 0);
      check("R1 reset seek_err", int'(seek_err), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // table of seek vectors
      for (int i = 0; i < NV; i++) begin
         wait_idle();
         scan_pos = VECS[i].start;
         stuck    = VECS[i].stuck;
         fall_cnt = 0;
         send_cmd(1'b0, VECS[i].chan);
         check("R7 busy after seek accept", int'(busy), 1);
         if (i == 3) begin
            // R10: strobes while busy are dropped
            send_cmd(1'b1, 8'd39);
            send_cmd(1'b0, 8'd9);
         end
         wait_done("R7 done seen");
         check("R3 R4 R6 pulse count", fall_cnt, int'(VECS[i].pulses));
         check("R5 seek_err at done", int'(seek_err), int'(VECS[i].err));
         check("R7 busy low at done", int'(busy), 0);
         @(negedge clk);
         check("R7 done one cycle", int'(done), 0);
         if (VECS[i].err) begin
            repeat (50) @(negedge clk);
            check("R11 seek_err held", int'(seek_err), 1);
            check("R5 no stepping after timeout", fall_cnt, 255);
         end
         if (i == 3) begin
            repeat (300) @(negedge clk);
            check("R10 ignored continuous command", fall_cnt, int'(VECS[i].pulses));
         end
      end
      stuck = 1'b0;

      // continuous mode periods
      wait_idle();
      send_cmd(1'b1, 8'd39);
      get_gap(gap);
      check("R8 gap period 39", gap, 40);
      wait_idle();
      send_cmd(1'b1, 8'd255);
      get_gap(gap);
      check("R8 gap period 255", gap, 256);
      wait_idle();
      send_cmd(1'b1, 8'd0);
      get_gap(gap);
      check("R8 gap period 0 drops ticks", gap, 21);

      // seek stops the timer
      wait_idle();
      scan_pos = 8'd0;
      fall_cnt = 0;
      send_cmd(1'b0, 8'd2);
      wait_done("R9 seek done");
      check("R9 seek pulses", fall_cnt, 2);
      repeat (600) @(negedge clk);
      check("R9 timer stopped", fall_cnt, 2);

      // error cleared by next command
      stuck = 1'b1;
      send_cmd(1'b0, 8'd0);
      wait_done("R5 timeout done");
      check("R5 timeout error", int'(seek_err), 1);
      stuck = 1'b0;
      wait_idle();
      send_cmd(1'b1, 8'd39);
      check("R11 error cleared by command", int'(seek_err), 0);

      // reset during continuous running
      f0 = rise_cnt;
      for (int k = 0; k < 2000 && rise_cnt == f0; k++) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 scan_clk low in reset", int'(scan_clk), 0);
      check("R1 busy low in reset", int'(busy), 0);
      rst_n = 1'b1;
      f0 = rise_cnt;
      repeat (600) @(negedge clk);
      check("R1 no pulses after reset", rise_cnt - f0, 0);
      check("R1 seek_err after reset", int'(seek_err), 0);

      summary();
   end

endmodule